// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block sits beside a program sequencer and decides which interrupt gets service next. It watches fifteen hardware request lines (sources 0 to 14) and one software request (source 15). It gates them with a global enable bit and a per-source mask. It picks the eligible request with the best fixed priority and presents a vector address: the base of the reset-and-interrupt area, hex E0000, plus four times the source number. Source number and priority are deliberately decoupled. The priority table is fixed and non-monotonic. Four source numbers are reserved and are never chosen.

The sequencer takes an interrupt by pulsing its accept strobe while a request is pending. The block then clears the global enable. It captures the return address and status word offered at that moment and issues two stack push beats over a valid/ready handshake: return address first, status word second. A busy flag covers the pushes. Nesting is left to software: priority only orders requests that are pending at the same time, and nothing interrupts a routine unless software sets the enable again. After reset the block first offers the reset entry at E0000, which is taken without any push.

The controller is a four-state machine:
- ST_RSTVEC: the reset entry is offered. On accept it moves to ST_IDLE.
- ST_IDLE: requests are arbitrated. An accept of source 0 stays in ST_IDLE. An accept of any other source moves to ST_PUSH_RA.
- ST_PUSH_RA: the return address is pushed. When the push is taken it moves to ST_PUSH_SR.
- ST_PUSH_SR: the status word is pushed. When the push is taken it moves back to ST_IDLE.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is held and on leaving reset, the block is in ST_RSTVEC with the following outputs:
  - irq_pend is 1, irq_src is 0 and irq_vec is hex E0000.
  - busy and push_valid are 0.
  - The mask register and the enable bit read back as 0.
- R2: Whenever irq_pend is 1, irq_vec equals hex E0000 plus 4 times irq_src.
- R3: Among eligible pending sources, the one with the best rank is chosen. The ranks, best first, are sources 0, 1, 2, 12, 4, 5, 11, 7, 9, 3, 13, 15.
- R4: Sources 6, 8, 10 and 14 are reserved. They never raise irq_pend and are never reported on irq_src, whatever the mask and enable settings.
- R5: Sources 0, 1, 2 and 15 are eligible whenever requested, regardless of the enable bit and the mask.
- R6: Every other non-reserved source n is eligible only when the enable bit is 1 and mask bit n is 1.
- R7: Request lines are level-sensitive and are registered on the rising clock edge. A line driven high becomes visible on irq_pend and irq_src after that one register stage.
- R8: Accepting a source other than 0 in ST_IDLE starts the push sequence:
  - The enable bit is cleared.
  - The first push beat carries the return address and the second carries the status word, both as sampled in the accept cycle.
  - Each beat completes only when push_ready is 1. While it stalls, push_valid stays high and push_data holds its value.
  - busy is 1 from the cycle after the accept until the second beat completes.
- R9: While busy is 1, irq_pend is 0 and irq_ack is ignored.
- R10: The register port works as follows:
  - reg_sel = 0 selects the 16-bit mask register, where bit n is source n.
  - reg_sel = 1 selects the enable bit at bit 0.
  - reg_rdata shows the selected register at all times.
  - A write takes effect from the cycle after reg_we is sampled. An accept in the same cycle wins over a write of the enable bit.
- R11: Accepting the reset entry (ST_RSTVEC) or source 0 produces no push beat. The block stays in or returns to ST_IDLE, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 15 | Hardware request lines, bit n is source n |
| sw_req | input | 1 | Software request (source 15) |
| irq_ack | input | 1 | Accept strobe from the sequencer |
| ret_addr | input | 20 | Return address to save on accept |
| status_word | input | 20 | Status word to save on accept |
| irq_pend | output | 1 | An interrupt is offered |
| irq_src | output | 4 | Source number being offered |
| irq_vec | output | 20 | Vector address for the offered source |
| push_valid | output | 1 | Stack push beat valid |
| push_data | output | 20 | Stack push data |
| push_ready | input | 1 | Stack accepts the push beat |
| busy | output | 1 | Push sequence in progress |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mask, 1 selects the enable bit |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
Directed cases pair sources whose rank order differs from their number order, for example 3 against 13 and 12 against 4. These catch an arbiter that simply picks the lowest or the highest number. A request on reserved sources only, with every gate open, checks that those sources stay silent. Unmaskable sources are requested with the gates closed, to show they bypass masking. Random request, mask and enable patterns are compared with a bench model of eligibility and rank. Random accepts with random push_ready stalls check the beat order, the data held during a stall, the ignored accepts while busy, and the cleared enable afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_HW  = 15;
    localparam int NUM_SRC = NUM_HW + 1;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int RANK_W  = SRC_W + 1;

    localparam logic [NUM_SRC-1:0] UNMASK_SET = 16'h8007;

    typedef enum logic [1:0] {
        ST_RSTVEC  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_PUSH_RA = 2'd2,
        ST_PUSH_SR = 2'd3
    } seq_state_t;

    // Rank 1 is best. Rank 0 marks a reserved source.
    function automatic logic [RANK_W-1:0] src_rank(input int src);
        logic [RANK_W-1:0] r;
        unique case (src)
            0:       r = 5'd1;
            1:       r = 5'd2;
            2:       r = 5'd3;
            3:       r = 5'd10;
            4:       r = 5'd5;
            5:       r = 5'd6;
            7:       r = 5'd8;
            9:       r = 5'd9;
            11:      r = 5'd7;
            12:      r = 5'd4;
            13:      r = 5'd11;
            15:      r = 5'd16;
            default: r = 5'd0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw_req,
    output logic [NUM_SRC-1:0] req_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= raw_req;
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic               ie_clr,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               ie_q,
    output logic [NUM_SRC-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_en && !wr_sel) mask_q <= wr_data;
            if (ie_clr)                 ie_q <= 1'b0;
            else if (wr_en && wr_sel)   ie_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (wr_sel) rd_data[0] = ie_q;
        else        rd_data    = mask_q;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic               ie_q,
    output logic               any,
    output logic [SRC_W-1:0]   sel
);
    logic [NUM_SRC-1:0] elig;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        localparam logic IS_RSVD = (src_rank(g) == '0);
        localparam logic IS_FREE = UNMASK_SET[g];
        if (IS_RSVD) begin : g_rsvd
            assign elig[g] = 1'b0;
        end else if (IS_FREE) begin : g_free
            assign elig[g] = req_q[g];
        end else begin : g_gated
            assign elig[g] = req_q[g] & ie_q & mask_q[g];
        end
    end

    logic [RANK_W-1:0] best;
    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (src_rank(i) < best)) begin
                any  = 1'b1;
                best = src_rank(i);
                sel  = i[SRC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic [SRC_W-1:0]  sel,
    input  logic              ack,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [DATA_W-1:0] status_word,
    input  logic              push_ready,
    output logic              pend,
    output logic [SRC_W-1:0]  src,
    output logic              take,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              busy
);
    seq_state_t state, nxt;
    logic [ADDR_W-1:0] ra_q;
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] ra_ext;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RSTVEC:  if (ack) nxt = ST_IDLE;
            ST_IDLE:    if (ack && any && (sel != '0)) nxt = ST_PUSH_RA;
            ST_PUSH_RA: if (push_ready) nxt = ST_PUSH_SR;
            ST_PUSH_SR: if (push_ready) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RSTVEC;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra_q <= '0;
            sr_q <= '0;
        end else if (state == ST_IDLE && ack && any) begin
            ra_q <= ret_addr;
            sr_q <= status_word;
        end
    end

    always_comb begin
        ra_ext = '0;
        ra_ext[ADDR_W-1:0] = ra_q;
    end

    always_comb begin
        pend       = 1'b0;
        src        = '0;
        push_valid = 1'b0;
        push_data  = '0;
        busy       = 1'b0;
        unique case (state)
            ST_RSTVEC: pend = 1'b1;
            ST_IDLE: begin
                pend = any;
                src  = any ? sel : '0;
            end
            ST_PUSH_RA: begin
                busy       = 1'b1;
                push_valid = 1'b1;
                push_data  = ra_ext;
            end
            ST_PUSH_SR: begin
                busy       = 1'b1;
                push_valid = 1'b1;
                push_data  = sr_q;
            end
            default: ;
        endcase
        take = pend & ack;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                DATA_W   = 20,
    parameter logic [ADDR_W-1:0] VEC_BASE = 20'hE0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_HW-1:0]  irq_req,
    input  logic               sw_req,
    input  logic               irq_ack,
    input  logic [ADDR_W-1:0]  ret_addr,
    input  logic [DATA_W-1:0]  status_word,
    output logic               irq_pend,
    output logic [SRC_W-1:0]   irq_src,
    output logic [ADDR_W-1:0]  irq_vec,
    output logic               push_valid,
    output logic [DATA_W-1:0]  push_data,
    input  logic               push_ready,
    output logic               busy,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               ie_q;
    logic               any;
    logic [SRC_W-1:0]   sel;
    logic               take;

    irq_sampler u_samp (
        .clk(clk), .rst_n(rst_n),
        .raw_req({sw_req, irq_req}),
        .req_q(req_q)
    );

    irq_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .ie_clr(take),
        .mask_q(mask_q), .ie_q(ie_q), .rd_data(reg_rdata)
    );

    irq_arbiter u_arb (
        .req_q(req_q), .mask_q(mask_q), .ie_q(ie_q),
        .any(any), .sel(sel)
    );

    irq_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .any(any), .sel(sel), .ack(irq_ack),
        .ret_addr(ret_addr), .status_word(status_word),
        .push_ready(push_ready),
        .pend(irq_pend), .src(irq_src), .take(take),
        .push_valid(push_valid), .push_data(push_data), .busy(busy)
    );

    assign irq_vec = VEC_BASE + ADDR_W'({irq_src, 2'b00});
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
    import irq_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_HW-1:0]  irq_req,
    input logic               sw_req,
    input logic               irq_ack,
    input logic               irq_pend,
    input logic [SRC_W-1:0]   irq_src,
    input logic               push_valid,
    input logic               push_ready,
    input logic [DATA_W-1:0]  push_data,
    input logic               busy,
    input logic               ie_q
);
    AST_BUSY_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_pend); // R9

    AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> !(irq_src == 4'd6 || irq_src == 4'd8 || irq_src == 4'd10 || irq_src == 4'd14)); // R4

    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && irq_ack) |=> !ie_q); // R8

    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_data))); // R8

    AST_SRC_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && irq_src != '0) |-> ((($past({sw_req, irq_req}) >> irq_src) & 16'd1) == 16'd1)); // R7
endmodule

bind irq_vector_ctrl irq_vector_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_req(sw_req),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .irq_src(irq_src),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .busy(busy), .ie_q(ie_q)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] irq_req = '0;
    logic        sw_req = 1'b0;
    logic        irq_ack = 1'b0;
    logic [19:0] ret_addr = '0;
    logic [19:0] status_word = '0;
    logic        irq_pend;
    logic [3:0]  irq_src;
    logic [19:0] irq_vec;
    logic        push_valid;
    logic [19:0] push_data;
    logic        push_ready = 1'b1;
    logic        busy;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_req(sw_req),
        .irq_ack(irq_ack), .ret_addr(ret_addr), .status_word(status_word),
        .irq_pend(irq_pend), .irq_src(irq_src), .irq_vec(irq_vec),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .busy(busy), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [15:0] req, input logic [15:0] mask,
                                  input logic ie, output logic found, output logic [3:0] src);
        int order [12] = '{0, 1, 2, 12, 4, 5, 11, 7, 9, 3, 13, 15};
        found = 1'b0;
        src = '0;
        for (int k = 0; k < 12; k++) begin
            int s = order[k];
            logic free = (s == 0 || s == 1 || s == 2 || s == 15);
            if (!found && req[s] && (free || (ie && mask[s]))) begin
                found = 1'b1;
                src = s[3:0];
            end
        end
    endfunction

    task automatic wr_reg(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic set_req(input logic [15:0] r);
        @(negedge clk);
        irq_req = r[14:0]; sw_req = r[15];
        @(negedge clk);
    endtask

    task automatic check_sel(input string tag, input logic [15:0] req,
                             input logic [15:0] mask, input logic ie);
        logic f;
        logic [3:0] s;
        model(req, mask, ie, f, s);
        chk({tag, " pend"}, {31'd0, irq_pend}, {31'd0, f});
        if (f) begin
            chk({tag, " src"}, {28'd0, irq_src}, {28'd0, s});
            chk({tag, " R2 vec"}, {12'd0, irq_vec}, 32'hE0000 + 32'(s) * 4);
        end
    endtask

    // At a negedge with irq_pend high: accept, then drive the two push beats
    // with random stalls and check order, data and the cleared enable bit.
    task automatic accept_and_check(input logic [3:0] s, input bit stall);
        logic [19:0] ra = 20'($urandom);
        logic [19:0] sr = 20'($urandom);
        logic [15:0] d;
        int beats = 0;
        irq_ack = 1'b1; ret_addr = ra; status_word = sr;
        @(negedge clk);
        irq_ack = 1'b0; ret_addr = ~ra; status_word = ~sr;
        if (s == 4'd0) begin
            chk("R11 no push on source 0", {30'd0, push_valid, busy}, 32'd0);
        end else begin
            chk("R8 busy after accept", {31'd0, busy}, 32'd1);
            chk("R9 no pend while busy", {31'd0, irq_pend}, 32'd0);
            for (int n = 0; n < 40 && beats < 2; n++) begin
                push_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
                irq_ack = 1'($urandom_range(0, 1));
                #1;
                chk("R8 push valid", {31'd0, push_valid}, 32'd1);
                chk("R8 push data order", {12'd0, push_data}, {12'd0, (beats == 0) ? ra : sr});
                if (push_ready) beats++;
                @(negedge clk);
            end
            irq_ack = 1'b0;
            push_ready = 1'b1;
            chk("R8 two beats", 32'(beats), 32'd2);
            chk("R8 busy done", {30'd0, busy, push_valid}, 32'd0);
        end
        rd_reg(1'b1, d);
        chk("R8 enable cleared", {16'd0, d}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] req, mask;
        logic ie;
        logic f;
        logic [3:0] s;
        process::self().srandom(32'h1234);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 pend in reset", {31'd0, irq_pend}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pend", {31'd0, irq_pend}, 32'd1);
        chk("R1 src", {28'd0, irq_src}, 32'd0);
        chk("R1 vec", {12'd0, irq_vec}, 32'hE0000);
        chk("R1 busy/push", {30'd0, busy, push_valid}, 32'd0);
        rd_reg(1'b0, d); chk("R1 mask", {16'd0, d}, 32'd0);
        rd_reg(1'b1, d); chk("R1 ie", {16'd0, d}, 32'd0);

        // R11 reset entry taken without pushes
        accept_and_check(4'd0, 1'b0);
        chk("R11 idle no pend", {31'd0, irq_pend}, 32'd0);

        // R10 register readback
        wr_reg(1'b0, 16'hA5C3);
        rd_reg(1'b0, d); chk("R10 mask readback", {16'd0, d}, 32'hA5C3);

        // R6 gated source blocked until enable; R10 enable write next cycle
        wr_reg(1'b0, 16'h0010);
        set_req(16'h0010);
        chk("R6 blocked by ie", {31'd0, irq_pend}, 32'd0);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0001;
        #1 chk("R10 ie not yet", {31'd0, irq_pend}, 32'd0);
        @(negedge clk);
        reg_we = 1'b0;
        chk("R10 ie effect next cycle", {31'd0, irq_pend}, 32'd1);
        chk("R6 src 4", {28'd0, irq_src}, 32'd4);
        wr_reg(1'b0, 16'h0000);
        chk("R6 blocked by mask", {31'd0, irq_pend}, 32'd0);

        // R4 reserved sources with all gates open
        wr_reg(1'b0, 16'hFFFF);
        set_req(16'h4540);
        chk("R4 reserved silent", {31'd0, irq_pend}, 32'd0);

        // R5 unmaskable with gates closed
        wr_reg(1'b0, 16'h0000);
        wr_reg(1'b1, 16'h0000);
        set_req(16'h8000);
        check_sel("R5 sw", 16'h8000, 16'h0000, 1'b0);
        set_req(16'h8002);
        check_sel("R5 src1", 16'h8002, 16'h0000, 1'b0);

        // R7 line visible after one register stage
        set_req(16'h0000);
        @(negedge clk);
        irq_req = 15'h0004;
        #1 chk("R7 not yet", {31'd0, irq_pend}, 32'd0);
        @(negedge clk);
        chk("R7 visible", {28'd0, irq_src}, 32'd2);

        // R3 non-monotonic pairs
        wr_reg(1'b0, 16'hFFFF);
        wr_reg(1'b1, 16'h0001);
        set_req(16'h2008); check_sel("R3 3 vs 13", 16'h2008, 16'hFFFF, 1'b1);
        set_req(16'h1010); check_sel("R3 12 vs 4", 16'h1010, 16'hFFFF, 1'b1);
        set_req(16'h0880); check_sel("R3 11 vs 7", 16'h0880, 16'hFFFF, 1'b1);
        set_req(16'hA000); check_sel("R3 13 vs 15", 16'hA000, 16'hFFFF, 1'b1);
        set_req(16'h1001); check_sel("R3 0 vs 12", 16'h1001, 16'hFFFF, 1'b1);

        // R8 accept with stalls, R9 ignored acks while busy
        set_req(16'h0200);
        chk("R8 pre src 9", {28'd0, irq_src}, 32'd9);
        accept_and_check(4'd9, 1'b1);
        // R11 source 0 accept
        set_req(16'h0001);
        accept_and_check(4'd0, 1'b0);

        // random patterns
        for (int it = 0; it < 300; it++) begin
            req  = 16'($urandom);
            mask = 16'($urandom);
            ie   = 1'($urandom_range(0, 1));
            wr_reg(1'b0, mask);
            wr_reg(1'b1, {15'd0, ie});
            set_req(req);
            check_sel("R3 random", req, mask, ie);
            model(req, mask, ie, f, s);
            if (f && ($urandom_range(0, 3) == 0)) accept_and_check(s, 1'b1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule